// File: doc/BRIEF.md
# Compact 8-bit Stored-Program Processor

This block is a multi-cycle processor core with sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It fetches two-byte instructions from a byte-wide memory that holds both code and data. It decodes each instruction and executes it in a fixed four-cycle loop. Arithmetic and logic work only on registers. Memory is touched only by explicit load and store instructions.

The memory sits outside the core and is reached through a single port. That port has an 8-bit address, a write strobe and a synchronous read that returns data one clock after the address. The memory is 256 bytes because the address is 8 bits wide. Any write into the top register (index 15) is also presented on a registered output byte with a one-cycle valid pulse, so a program can stream characters by writing that register. A halt instruction, or any opcode outside the defined set, parks the core until the next reset.

Top module: `sp8_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the core drives memory address 0x00, the write strobe is low, `out_valid` is low and `halted` is low. All registers start at zero.
- R2: Every instruction takes two bytes. The high byte is read from address PC and the low byte from PC+1. PC advances by 2 modulo 256, so fetching past 0xFF continues at 0x00.
- R3: Instruction `2rxx` (high nibble 2) writes the immediate byte xx into register r.
- R4: Instruction `1rxx` writes memory[xx] into register r. Instruction `3rxx` writes register r into memory[xx] with a write strobe exactly one cycle wide.
- R5: Instruction `40st` copies register s into register t.
- R6: Instruction `5rst` writes (Rs + Rt) mod 256 into Rr.
- R7: Instructions `7rst`, `8rst` and `9rst` write Rs OR Rt, Rs AND Rt and Rs XOR Rt into Rr.
- R8: Instruction `Ar0x` rotates register r right by (x mod 8) bit positions. Bits that leave the low end re-enter at the top.
- R9: Instruction `Brxx` loads xx into PC when register r equals R0, and otherwise falls through to PC+2. `B0xx` is therefore always taken.
- R10: Instruction `C000` halts the core. Every opcode outside {1,2,3,4,5,7,8,9,A,B} also halts it. Once halted, `halted` stays high and no memory write or output pulse occurs until reset.
- R11: Each write into register 15 gives a one-cycle `out_valid` pulse with the written byte on `out_data`, one clock after the write.
- R12: Each executed instruction takes exactly four clocks. With k instructions before a halt, `halted` rises 4·(k+1) clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after the address |
| out_data | output | 8 | Byte last written into register 15 |
| out_valid | output | 1 | One-cycle pulse per register-15 write |
| halted | output | 1 | High once the core has stopped |

## Verification
A wrong register value stays hidden until a store or a register-15 write exposes it. The stimulus therefore ends every computation with a store and compares the stored byte with the value the bench computes itself, about eight clocks after the instruction that produced it. Errors in PC or fetch sequencing show up as outputs that are missing or appear at the wrong time. They also show up as a halt that comes at the wrong cycle count, because every instruction has a fixed length of four clocks. A halt state that leaks would appear as a write strobe or output pulse after `halted` rises, and the bench watches for that directly.

// File: rtl/sp8_pkg.sv
package sp8_pkg;
  typedef enum logic [2:0] {
    ST_FETCH_HI, ST_FETCH_LO, ST_DECODE, ST_EXEC, ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_OR, ALU_AND, ALU_XOR, ALU_ROR
  } alu_op_t;

  localparam logic [3:0] OP_LDM  = 4'h1;
  localparam logic [3:0] OP_LDI  = 4'h2;
  localparam logic [3:0] OP_STM  = 4'h3;
  localparam logic [3:0] OP_MOV  = 4'h4;
  localparam logic [3:0] OP_ADD  = 4'h5;
  localparam logic [3:0] OP_OR   = 4'h7;
  localparam logic [3:0] OP_AND  = 4'h8;
  localparam logic [3:0] OP_XOR  = 4'h9;
  localparam logic [3:0] OP_ROR  = 4'hA;
  localparam logic [3:0] OP_JEQ  = 4'hB;
endpackage

// File: rtl/sp8_regfile.sv
module sp8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b,
  output logic [DW-1:0]  rdata_z
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_z = regs[0];
endmodule

// File: rtl/sp8_alu.sv
module sp8_alu
  import sp8_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SHW = $clog2(DW)
) (
  input  alu_op_t        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [SHW-1:0] amt,
  output logic [DW-1:0]  y
);
  logic [2*DW-1:0] dbl;

  always_comb begin
    dbl = {a, a} >> amt;
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_OR:  y = a | b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      ALU_ROR: y = dbl[DW-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/sp8_ctrl.sv
module sp8_ctrl
  import sp8_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  parameter int RAW = 4,
  parameter int SHW = $clog2(DW),
  localparam int IW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW-1:0]  rd_a,
  input  logic [DW-1:0]  rd_z,
  input  logic [DW-1:0]  alu_y,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic [RAW-1:0] ra_a,
  output logic [RAW-1:0] ra_b,
  output logic           rf_we,
  output logic [RAW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output alu_op_t        alu_op,
  output logic [SHW-1:0] alu_amt,
  output logic           halted
);
  state_t        state;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic [3:0]    opc;
  logic [RAW-1:0] f_r, f_s, f_t;
  logic [DW-1:0] imm;
  logic          op_valid, op_wr;

  assign opc = ir[IW-1 -: 4];
  assign f_r = ir[11:8];
  assign f_s = ir[7:4];
  assign f_t = ir[3:0];
  assign imm = ir[DW-1:0];

  always_comb begin
    unique case (opc)
      OP_LDM, OP_LDI, OP_STM, OP_MOV, OP_ADD, OP_OR,
      OP_AND, OP_XOR, OP_ROR, OP_JEQ: op_valid = 1'b1;
      default:                        op_valid = 1'b0;
    endcase
    unique case (opc)
      OP_LDM, OP_LDI, OP_MOV, OP_ADD, OP_OR,
      OP_AND, OP_XOR, OP_ROR: op_wr = 1'b1;
      default:                op_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH_HI;
      pc    <= '0;
      ir    <= '0;
    end else begin
      unique case (state)
        ST_FETCH_HI: state <= ST_FETCH_LO;
        ST_FETCH_LO: begin
          ir[IW-1:DW] <= mem_rdata;
          state       <= ST_DECODE;
        end
        ST_DECODE: begin
          ir[DW-1:0] <= mem_rdata;
          pc         <= pc + AW'(2);
          state      <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!op_valid) state <= ST_HALT;
          else           state <= ST_FETCH_HI;
          if (opc == OP_JEQ && rd_a == rd_z) pc <= AW'(imm);
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_FETCH_LO: mem_addr = pc + AW'(1);
      ST_DECODE:   mem_addr = AW'(mem_rdata);
      ST_EXEC:     mem_addr = AW'(imm);
      default:     mem_addr = pc;
    endcase
  end

  assign mem_we = (state == ST_EXEC) && (opc == OP_STM);
  assign halted = (state == ST_HALT);

  assign ra_a = (opc == OP_STM || opc == OP_ROR || opc == OP_JEQ) ? f_r : f_s;
  assign ra_b = f_t;
  assign alu_amt = f_t[SHW-1:0];

  always_comb begin
    unique case (opc)
      OP_OR:   alu_op = ALU_OR;
      OP_AND:  alu_op = ALU_AND;
      OP_XOR:  alu_op = ALU_XOR;
      OP_ROR:  alu_op = ALU_ROR;
      default: alu_op = ALU_ADD;
    endcase
    unique case (opc)
      OP_LDM:  rf_wdata = mem_rdata;
      OP_LDI:  rf_wdata = imm;
      OP_MOV:  rf_wdata = rd_a;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we    = (state == ST_EXEC) && op_wr;
  assign rf_waddr = (opc == OP_MOV) ? f_t : f_r;
endmodule

// File: rtl/sp8_cpu.sv
module sp8_cpu
  import sp8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG),
  localparam int SHW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  logic [RAW-1:0] ra_a, ra_b, waddr;
  logic [DW-1:0]  rd_a, rd_b, rd_z, wdata, alu_y;
  logic           rf_we;
  alu_op_t        alu_op;
  logic [SHW-1:0] alu_amt;

  sp8_regfile #(.DW(DW), .NREG(NREG), .RAW(RAW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(waddr), .wdata(wdata),
    .raddr_a(ra_a), .raddr_b(ra_b),
    .rdata_a(rd_a), .rdata_b(rd_b), .rdata_z(rd_z)
  );

  sp8_alu #(.DW(DW), .SHW(SHW)) u_alu (
    .op(alu_op), .a(rd_a), .b(rd_b), .amt(alu_amt), .y(alu_y)
  );

  sp8_ctrl #(.DW(DW), .AW(AW), .RAW(RAW), .SHW(SHW)) u_ctrl (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata),
    .rd_a(rd_a), .rd_z(rd_z), .alu_y(alu_y),
    .mem_addr(mem_addr), .mem_we(mem_we),
    .ra_a(ra_a), .ra_b(ra_b),
    .rf_we(rf_we), .rf_waddr(waddr), .rf_wdata(wdata),
    .alu_op(alu_op), .alu_amt(alu_amt), .halted(halted)
  );

  assign mem_wdata = rd_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rf_we && (waddr == RAW'(NREG - 1));
      if (rf_we && (waddr == RAW'(NREG - 1))) out_data <= wdata;
    end
  end
endmodule

// File: rtl/sp8_cpu_chk.sv
module sp8_cpu_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          out_valid,
  input logic          halted
);
  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_addr == '0 && !mem_we && !out_valid && !halted));

  assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && !out_valid));

  assert_no_write_halted_R10: assert property (@(posedge clk) disable iff (rst)
    !(halted && mem_we));

  assert_out_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind sp8_cpu sp8_cpu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .out_valid(out_valid), .halted(halted)
);

// File: tb/tb_sp8_cpu.sv
`timescale 1ns/1ps
module tb_sp8_cpu;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] mem_addr, mem_wdata, out_data;
  logic [7:0] mem_rdata;
  logic       mem_we, out_valid, halted;

  logic [7:0] mem [256];
  logic [7:0] outs [64];
  int         out_cyc [64];
  int         n_out;
  int         checks = 0;
  int         errors = 0;
  int         late_wr;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  sp8_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int addr, input logic [15:0] ins);
    mem[addr[7:0]]          = ins[15:8];
    mem[8'(addr + 1)]       = ins[7:0];
  endtask

  task automatic run_prog(input int max_cyc, output int cyc);
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    n_out = 0;
    cyc = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (out_valid && n_out < 64) begin
        outs[n_out] = out_data;
        out_cyc[n_out] = cyc;
        n_out++;
      end
      if (halted) break;
      if (cyc >= max_cyc) begin
        chk("watchdog", cyc, -1);
        break;
      end
    end
  endtask

  function automatic logic [7:0] exp_alu(input logic [3:0] op,
      input logic [7:0] a, input logic [7:0] b, input int amt);
    logic [7:0] r;
    case (op)
      4'h5: r = a + b;
      4'h7: r = a | b;
      4'h8: r = a & b;
      4'h9: r = a ^ b;
      default: begin
        r = a;
        for (int k = 0; k < amt % 8; k++) r = {r[0], r[7:1]};
      end
    endcase
    return r;
  endfunction

  task automatic alu_case(input logic [3:0] op, input logic [7:0] a,
      input logic [7:0] b, input int amt);
    int cyc;
    string req;
    clear_mem();
    put(0, {8'h21, a});
    put(2, {8'h22, b});
    put(4, 16'h4013);
    if (op == 4'hA) put(6, {8'hA3, 4'h0, 4'(amt)});
    else            put(6, {op, 4'h3, 4'h1, 4'h2});
    put(8, 16'h33E0);
    put(10, 16'hC000);
    run_prog(200, cyc);
    case (op)
      4'h5: req = "R6 add";
      4'hA: req = "R8 rotate";
      default: req = "R7 logic";
    endcase
    chk(req, mem[8'hE0], exp_alu(op, a, b, amt));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int dummy;
    logic [3:0] ops [5];
    ops[0] = 4'h5; ops[1] = 4'h7; ops[2] = 4'h8; ops[3] = 4'h9; ops[4] = 4'hA;
    dummy = $urandom(1234);

    // R1: reset state
    clear_mem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", mem_addr, 0);
    chk("R1 reset we", mem_we, 0);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset halted", halted, 0);

    // R3 R6 R11 R12: output stream 0,1,2 then halt
    clear_mem();
    put(0, 16'h2F00); put(2, 16'h2701); put(4, 16'h5FF7);
    put(6, 16'h5FF7); put(8, 16'hC000);
    run_prog(200, cyc);
    chk("R11 out count", n_out, 3);
    chk("R3 R11 out0", outs[0], 8'h00);
    chk("R6 R11 out1", outs[1], 8'h01);
    chk("R6 R11 out2", outs[2], 8'h02);
    chk("R11 out timing", out_cyc[0], 4);
    chk("R12 halt cycle", cyc, 20);
    late_wr = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!halted || mem_we || out_valid) late_wr++;
    end
    chk("R10 stays halted", late_wr, 0);

    // R1: registers start at zero (store R5 without writing it)
    clear_mem();
    mem[8'h70] = 8'hAA;
    put(0, 16'h3570); put(2, 16'hC000);
    run_prog(100, cyc);
    chk("R1 regs zero", mem[8'h70], 8'h00);

    // R4 R5: load, move, store
    clear_mem();
    mem[8'h80] = 8'h5A;
    put(0, 16'h1380); put(2, 16'h4035); put(4, 16'h3590); put(6, 16'hC000);
    run_prog(100, cyc);
    chk("R4 R5 stored", mem[8'h90], 8'h5A);
    chk("R4 source kept", mem[8'h80], 8'h5A);

    // R9: taken jump
    clear_mem();
    put(0, 16'h2300); put(2, 16'hB308); put(4, 16'h2F11);
    put(6, 16'hC000); put(8, 16'h2F22); put(10, 16'hC000);
    run_prog(100, cyc);
    chk("R9 taken count", n_out, 1);
    chk("R9 taken value", outs[0], 8'h22);

    // R9: not taken
    clear_mem();
    put(0, 16'h2301); put(2, 16'hB308); put(4, 16'h2F11);
    put(6, 16'hC000); put(8, 16'h2F22); put(10, 16'hC000);
    run_prog(100, cyc);
    chk("R9 fall count", n_out, 1);
    chk("R9 fall value", outs[0], 8'h11);

    // R2: PC wraps from FE to 00
    clear_mem();
    put(0, 16'hBFFE); put(2, 16'hC000); put(254, 16'h2F44);
    run_prog(100, cyc);
    chk("R2 wrap count", n_out, 1);
    chk("R2 wrap value", outs[0], 8'h44);
    chk("R2 wrap cycles", cyc, 16);

    // R10: undefined opcode halts
    clear_mem();
    put(0, 16'h2F01); put(2, 16'h6000); put(4, 16'h2F02); put(6, 16'hC000);
    run_prog(100, cyc);
    chk("R10 undef count", n_out, 1);
    chk("R10 undef halted", halted, 1);
    chk("R10 undef cycles", cyc, 8);

    // directed ALU corners
    alu_case(4'h5, 8'hFF, 8'h01, 0);   // R6 wrap
    alu_case(4'hA, 8'hAB, 8'h00, 1);   // R8
    alu_case(4'hA, 8'h81, 8'h00, 0);   // R8 zero
    alu_case(4'hA, 8'h96, 8'h00, 7);   // R8
    alu_case(4'hA, 8'h96, 8'h00, 9);   // R8 mod 8

    // random
    for (int n = 0; n < 40; n++) begin
      alu_case(ops[$urandom % 5], 8'($urandom), 8'($urandom), int'($urandom % 16));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule